// File: doc/BRIEF.md
# Page Shadow Check Resolver

This block settles the slow path of a cross-module control-flow check. A caller hands it a target address, a 64-bit call-site type identifier and a diagnostic pointer. The diagnostic pointer is zero when the caller has no diagnostics. The block looks up the target's 4 KiB page in an external shadow table. Each page has one 16-bit entry in that table, and the block reads it over a simple request/response port whose latency can vary.

The block sorts the entry into one of three outcomes:

- The all-ones entry marks a trusted region that carries no instrumentation. The call is allowed without further checking.
- The all-zeros entry marks a target that belongs to no known module. The call is reported as a violation.
- Any other entry gives the distance in pages from the target down to the owning module's check routine. The block computes that routine's address and hands it on, together with the unchanged type identifier, target and diagnostic pointer, so that the routine can be dispatched.

The block handles one lookup at a time. It holds its result until the consumer accepts it.

Top module: `page_shadow_resolver`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `reqReady` is 1 and both `resValid` and `shReqValid` are 0.
- R2: For each accepted request the block raises `shReqValid` with `shReqIndex` equal to the target address shifted right by 12. It holds both unchanged until `shReqReady` is seen high.
- R3: A shadow entry of 16'hFFFF yields a result with `resAllow`=1 and the other two outcome flags 0.
- R4: A shadow entry of 16'h0000 yields a result with `resViolation`=1 and the other two outcome flags 0.
- R5: Any other shadow entry V yields `resDispatch`=1 and `resCheckAddr` = roundup(target, 4096) − (V+1)·4096, computed modulo 2^32.
- R6: When the target's low 12 bits are zero, the round-up leaves the target unchanged, so `resCheckAddr` = target − (V+1)·4096.
- R7: `resTypeId`, `resTarget` and `resDiag` equal the values that were accepted with the request. A zero diagnostic pointer comes out as zero.
- R8: Only one lookup is in flight. `reqReady` is 0 from the cycle after a request is accepted until the cycle after its result is accepted.
- R9: Whenever `resValid` is 1, exactly one outcome flag is 1. All result outputs stay stable until `resReady` is seen high, and `resValid` is 0 on the cycle after acceptance. No outcome flag is 1 while `resValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup request offered |
| reqReady | output | 1 | Block idle and accepting a request |
| reqTypeId | input | 64 | Call-site type identifier |
| reqTarget | input | 32 | Call target address |
| reqDiag | input | 32 | Diagnostic pointer, zero when absent |
| shReqValid | output | 1 | Shadow read request |
| shReqReady | input | 1 | Shadow memory takes the read |
| shReqIndex | output | 20 | Page index (target >> 12) |
| shRspValid | input | 1 | Shadow read data present |
| shRspData | input | 16 | Shadow entry |
| resValid | output | 1 | Result present |
| resReady | input | 1 | Consumer takes the result |
| resAllow | output | 1 | Trusted region, call allowed |
| resViolation | output | 1 | Invalid target |
| resDispatch | output | 1 | Forward to the check routine |
| resCheckAddr | output | 32 | Check routine address |
| resTypeId | output | 64 | Forwarded type identifier |
| resTarget | output | 32 | Forwarded target |
| resDiag | output | 32 | Forwarded diagnostic pointer |

## Verification
The shadow read request is due on the cycle after a request is accepted, so `reqReady` must already be low at the next sampling point. The result is due one cycle after the edge that samples `shRspValid`. `resValid` drops one cycle after the edge that samples `resReady`. The bench model of the shadow memory stretches both the grant and the response by a different number of cycles on each request. The consumer holds off `resReady` for a chosen number of cycles and compares every result field again before accepting it. All sampling happens on the falling edge, half a cycle after the registers update, so each check lands in the cycle its result is due.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_DONE
  } psr_state_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capReq;     // latch request fields
    logic capShadow;  // latch returned shadow entry
  } psr_strobe_t;

endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        shReqReady,
  input  logic        shRspValid,
  input  logic        resReady,
  output logic        reqReady,
  output logic        shReqValid,
  output logic        resValid,
  output psr_strobe_t strobe
);

  psr_state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid)   stateNext = ST_READ;
      ST_READ: if (shReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (shRspValid) stateNext = ST_DONE;
      ST_DONE: if (resReady)   stateNext = ST_IDLE;
      default:                 stateNext = ST_IDLE;
    endcase
  end

  assign reqReady         = (state == ST_IDLE);
  assign shReqValid       = (state == ST_READ);
  assign resValid         = (state == ST_DONE);
  assign strobe.capReq    = (state == ST_IDLE) && reqValid;
  assign strobe.capShadow = (state == ST_WAIT) && shRspValid;

endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TYPE_W    = 64,
  parameter int SHADOW_W  = 16,
  parameter int PAGE_BITS = 12,
  localparam int PAGE_NUM_W = ADDR_W - PAGE_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  psr_strobe_t           strobe,
  input  logic                  resValid,
  input  logic [TYPE_W-1:0]     reqTypeId,
  input  logic [ADDR_W-1:0]     reqTarget,
  input  logic [ADDR_W-1:0]     reqDiag,
  input  logic [SHADOW_W-1:0]   shRspData,
  output logic [PAGE_NUM_W-1:0] shReqIndex,
  output logic                  resAllow,
  output logic                  resViolation,
  output logic                  resDispatch,
  output logic [ADDR_W-1:0]     resCheckAddr,
  output logic [TYPE_W-1:0]     resTypeId,
  output logic [ADDR_W-1:0]     resTarget,
  output logic [ADDR_W-1:0]     resDiag
);

  localparam logic [SHADOW_W-1:0] TRUSTED_CODE = '1;
  localparam logic [SHADOW_W-1:0] INVALID_CODE = '0;

  logic [TYPE_W-1:0]   typeIdReg;
  logic [ADDR_W-1:0]   targetReg;
  logic [ADDR_W-1:0]   diagReg;
  logic [SHADOW_W-1:0] shadowReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeIdReg <= '0;
      targetReg <= '0;
      diagReg   <= '0;
    end else if (strobe.capReq) begin
      typeIdReg <= reqTypeId;
      targetReg <= reqTarget;
      diagReg   <= reqDiag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shadowReg <= '0;
    else if (strobe.capShadow) shadowReg <= shRspData;
  end

  // page arithmetic: round target up to a page, step back (V+1) pages
  logic [PAGE_NUM_W-1:0] targetPage;
  logic                  offsetNonZero;
  logic [PAGE_NUM_W-1:0] roundedPage;
  logic [PAGE_NUM_W-1:0] shadowWide;
  logic [PAGE_NUM_W-1:0] checkPage;

  assign targetPage    = targetReg[ADDR_W-1:PAGE_BITS];
  assign offsetNonZero = |targetReg[PAGE_BITS-1:0];
  assign roundedPage   = targetPage + PAGE_NUM_W'(offsetNonZero);

  generate
    if (PAGE_NUM_W > SHADOW_W) begin : g_extend
      assign shadowWide = {{(PAGE_NUM_W-SHADOW_W){1'b0}}, shadowReg};
    end else begin : g_trunc
      assign shadowWide = shadowReg[PAGE_NUM_W-1:0];
    end
  endgenerate

  assign checkPage    = roundedPage - shadowWide - PAGE_NUM_W'(1);
  assign resCheckAddr = {checkPage, {PAGE_BITS{1'b0}}};

  logic isTrusted, isInvalid;
  assign isTrusted = (shadowReg == TRUSTED_CODE);
  assign isInvalid = (shadowReg == INVALID_CODE);

  assign resAllow     = resValid && isTrusted;
  assign resViolation = resValid && isInvalid;
  assign resDispatch  = resValid && !isTrusted && !isInvalid;

  assign shReqIndex = targetPage;
  assign resTypeId  = typeIdReg;
  assign resTarget  = targetReg;
  assign resDiag    = diagReg;

endmodule

// File: rtl/page_shadow_resolver.sv
module page_shadow_resolver
  import psr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TYPE_W    = 64,
  parameter int SHADOW_W  = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [TYPE_W-1:0]           reqTypeId,
  input  logic [ADDR_W-1:0]           reqTarget,
  input  logic [ADDR_W-1:0]           reqDiag,
  output logic                        shReqValid,
  input  logic                        shReqReady,
  output logic [ADDR_W-PAGE_BITS-1:0] shReqIndex,
  input  logic                        shRspValid,
  input  logic [SHADOW_W-1:0]         shRspData,
  output logic                        resValid,
  input  logic                        resReady,
  output logic                        resAllow,
  output logic                        resViolation,
  output logic                        resDispatch,
  output logic [ADDR_W-1:0]           resCheckAddr,
  output logic [TYPE_W-1:0]           resTypeId,
  output logic [ADDR_W-1:0]           resTarget,
  output logic [ADDR_W-1:0]           resDiag
);

  psr_strobe_t strobe;

  psr_ctrl ctrlI (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .shReqReady (shReqReady),
    .shRspValid (shRspValid),
    .resReady   (resReady),
    .reqReady   (reqReady),
    .shReqValid (shReqValid),
    .resValid   (resValid),
    .strobe     (strobe)
  );

  psr_datapath #(
    .ADDR_W    (ADDR_W),
    .TYPE_W    (TYPE_W),
    .SHADOW_W  (SHADOW_W),
    .PAGE_BITS (PAGE_BITS)
  ) dpI (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .resValid     (resValid),
    .reqTypeId    (reqTypeId),
    .reqTarget    (reqTarget),
    .reqDiag      (reqDiag),
    .shRspData    (shRspData),
    .shReqIndex   (shReqIndex),
    .resAllow     (resAllow),
    .resViolation (resViolation),
    .resDispatch  (resDispatch),
    .resCheckAddr (resCheckAddr),
    .resTypeId    (resTypeId),
    .resTarget    (resTarget),
    .resDiag      (resDiag)
  );

endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqReady,
  input logic                        shReqValid,
  input logic                        shReqReady,
  input logic [ADDR_W-PAGE_BITS-1:0] shReqIndex,
  input logic                        resValid,
  input logic                        resReady,
  input logic                        resAllow,
  input logic                        resViolation,
  input logic                        resDispatch,
  input logic [ADDR_W-1:0]           resCheckAddr,
  input logic [ADDR_W-1:0]           resDiag
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (reqReady && !resValid && !shReqValid));

  // R2
  shreq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shReqValid && !shReqReady) |=> (shReqValid && $stable(shReqIndex)));

  // R8
  single_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!resValid && !shReqValid));

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($countones({resAllow, resViolation, resDispatch}) == 1));

  // R9
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !(resAllow || resViolation || resDispatch));

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resCheckAddr) &&
      $stable(resDiag) && $stable({resAllow, resViolation, resDispatch})));

endmodule

bind page_shadow_resolver psr_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_BITS (PAGE_BITS)
) chkI (
  .clk          (clk),
  .rstN         (rstN),
  .reqReady     (reqReady),
  .shReqValid   (shReqValid),
  .shReqReady   (shReqReady),
  .shReqIndex   (shReqIndex),
  .resValid     (resValid),
  .resReady     (resReady),
  .resAllow     (resAllow),
  .resViolation (resViolation),
  .resDispatch  (resDispatch),
  .resCheckAddr (resCheckAddr),
  .resDiag      (resDiag)
);

// File: tb/page_shadow_resolver_tb_top.sv
module page_shadow_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqTypeId = '0;
  logic [31:0] reqTarget = '0;
  logic [31:0] reqDiag = '0;
  logic        shReqValid;
  logic        shReqReady = 1'b0;
  logic [19:0] shReqIndex;
  logic        shRspValid = 1'b0;
  logic [15:0] shRspData = 16'h5A5A;
  logic        resValid;
  logic        resReady = 1'b0;
  logic        resAllow, resViolation, resDispatch;
  logic [31:0] resCheckAddr;
  logic [63:0] resTypeId;
  logic [31:0] resTarget, resDiag;

  always #10 clk = ~clk;  // 50 MHz

  page_shadow_resolver dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqTypeId(reqTypeId), .reqTarget(reqTarget), .reqDiag(reqDiag),
    .shReqValid(shReqValid), .shReqReady(shReqReady), .shReqIndex(shReqIndex),
    .shRspValid(shRspValid), .shRspData(shRspData),
    .resValid(resValid), .resReady(resReady), .resAllow(resAllow),
    .resViolation(resViolation), .resDispatch(resDispatch),
    .resCheckAddr(resCheckAddr), .resTypeId(resTypeId),
    .resTarget(resTarget), .resDiag(resDiag)
  );

  typedef struct {
    logic [2:0]  flags;  // {allow, violation, dispatch}
    logic [31:0] addr;
    logic [63:0] tid;
    logic [31:0] tgt;
    logic [31:0] diag;
    int          hold;
  } exp_t;

  typedef struct {
    logic [15:0] shadow;
    logic [19:0] idx;
    int          gnt;
    int          rsp;
  } mem_t;

  exp_t expQ[$];
  mem_t memQ[$];
  int   total = 0;
  int   failed = 0;
  bit   summaryDone = 0;

  task automatic checkEq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      failed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("%0d/%0d checks passed", total - failed, total);
    end
    $finish;
  endtask

  function automatic logic [31:0] expAddr(input logic [31:0] t, input logic [15:0] v);
    logic [31:0] up;
    up = (t[11:0] != 12'd0) ? ((t & 32'hFFFF_F000) + 32'h1000) : t;
    return up - ((32'(v) + 32'd1) << 12);
  endfunction

  // driver: pushes expectations, then offers the request
  task automatic sendReq(input logic [31:0] t, input logic [63:0] tid,
                         input logic [31:0] diag, input logic [15:0] v,
                         input int gnt, input int rsp, input int hold);
    exp_t e;
    mem_t m;
    while (!reqReady) @(negedge clk);
    e.flags = (v == 16'hFFFF) ? 3'b100 : (v == 16'h0000) ? 3'b010 : 3'b001;
    e.addr  = expAddr(t, v);
    e.tid   = tid;
    e.tgt   = t;
    e.diag  = diag;
    e.hold  = hold;
    m.shadow = v;
    m.idx    = t[31:12];
    m.gnt    = gnt;
    m.rsp    = rsp;
    expQ.push_back(e);
    memQ.push_back(m);
    reqTarget = t;
    reqTypeId = tid;
    reqDiag   = diag;
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid  = 1'b0;
    reqTarget = 32'hDEAD_BEEF;
    reqTypeId = 64'h0BAD_0BAD_0BAD_0BAD;
    reqDiag   = 32'hFFFF_FFFF;
    checkEq("R8", "reqReady after accept", reqReady, 0);
  endtask

  // shadow memory model with variable grant and response delay
  initial begin
    forever begin
      @(negedge clk);
      if (shReqValid) begin
        mem_t m;
        if (memQ.size() == 0) begin
          checkEq("R2", "unexpected shadow read", 1, 0);
        end else begin
          m = memQ.pop_front();
          checkEq("R2", "shReqIndex", shReqIndex, m.idx);
          repeat (m.gnt) @(negedge clk);
          checkEq("R2", "shReqValid held", shReqValid, 1);
          checkEq("R2", "shReqIndex held", shReqIndex, m.idx);
          shReqReady = 1'b1;
          @(negedge clk);
          shReqReady = 1'b0;
          repeat (m.rsp) @(negedge clk);
          shRspData  = m.shadow;
          shRspValid = 1'b1;
          @(negedge clk);
          shRspValid = 1'b0;
          shRspData  = 16'h5A5A;
        end
      end
    end
  end

  task automatic compareRes(input exp_t e, input string tag);
    string r;
    r = (e.flags == 3'b100) ? "R3" : (e.flags == 3'b010) ? "R4" : "R5";
    checkEq(r, {tag, " flags"}, {resAllow, resViolation, resDispatch}, e.flags);
    if (e.flags == 3'b001) checkEq("R5", {tag, " resCheckAddr"}, resCheckAddr, e.addr);
    checkEq("R7", {tag, " resTypeId"}, resTypeId, e.tid);
    checkEq("R7", {tag, " resTarget"}, resTarget, e.tgt);
    checkEq("R7", {tag, " resDiag"}, resDiag, e.diag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (resValid) begin
        exp_t e;
        if (expQ.size() == 0) begin
          checkEq("R9", "unexpected result", 1, 0);
        end else begin
          e = expQ.pop_front();
          compareRes(e, "first");
          repeat (e.hold) @(negedge clk);
          checkEq("R9", "resValid held", resValid, 1);
          compareRes(e, "held");
          resReady = 1'b1;
          @(negedge clk);
          resReady = 1'b0;
          checkEq("R9", "resValid after accept", resValid, 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checkEq("WDOG", "run finished", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkEq("R1", "reqReady in reset", reqReady, 1);
    checkEq("R1", "resValid in reset", resValid, 0);
    checkEq("R1", "shReqValid in reset", shReqValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "reqReady after reset", reqReady, 1);
    checkEq("R1", "resValid after reset", resValid, 0);

    // R3 trusted region
    sendReq(32'h0040_1234, 64'h1111_2222_3333_4444, 32'h0000_8000, 16'hFFFF, 0, 0, 0);
    // R4 invalid target
    sendReq(32'h0800_0FFF, 64'hAAAA_BBBB_CCCC_DDDD, 32'h0000_9000, 16'h0000, 2, 3, 2);
    // R5 dispatch, unaligned target
    sendReq(32'h1000_0ABC, 64'h0123_4567_89AB_CDEF, 32'h0000_A000, 16'h0001, 1, 0, 1);
    // R6 page-aligned target
    sendReq(32'h2000_3000, 64'hFEDC_BA98_7654_3210, 32'h0000_B000, 16'h0002, 0, 1, 3);
    // R5 largest distance
    sendReq(32'h3000_0001, 64'h5555_6666_7777_8888, 32'h0000_C000, 16'hFFFE, 3, 0, 0);
    // R7 null diagnostic pointer, long latencies
    sendReq(32'h4444_4444, 64'h0000_0000_0000_0001, 32'h0000_0000, 16'h0010, 5, 7, 4);
    // R6 aligned target with wrap below zero
    sendReq(32'h0000_1000, 64'h9999_0000_9999_0000, 32'h0000_D000, 16'h0003, 0, 2, 0);
    for (int k = 0; k < 8; k++) begin
      sendReq(32'h1234_5678 * (k + 3) ^ 32'(k << 12), 64'(k) * 64'h0101_0101_0101_0101,
              (k % 2 == 0) ? 32'h0 : 32'(k * 32'h40), 16'(k * 4099 + 7),
              k % 3, (k + 1) % 4, k % 2);
    end
    while (expQ.size() != 0 || memQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule